// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Unit

This unit stands between the interrupt sources of a system and a single processor core. It keeps three kinds of pending request: a reset request pulse, a non-maskable interrupt pulse, and a maskable interrupt level that arrives as a value together with a change strobe. It also holds the hardware-interrupt field of the core's cause register.

At each instruction boundary, which the core marks with a strobe, the unit looks at what is pending and serves only the most urgent request. The order is reset, then NMI, then the maskable level. A reset or NMI request raises one shared hard-exception request. A maskable level is first copied into the cause field. It then raises an interrupt-exception request only when the core's global enable is set and the level shares at least one bit with the status mask. A level that is blocked stays pending and is tried again at every later boundary. A level value of zero is an end-of-interrupt marker, and it clears the cause field.

Top module: `irq_dispatch`

## Requirements
- R1: After a synchronous reset, `cause_ip_o` is zero and `hard_exc_o` and `intr_exc_o` are low. A boundary that follows the reset, with no new request, raises no exception.
- R2: Pending requests are served one per boundary in a fixed order: reset request first, then NMI, then the maskable level. The cause field is not touched at a boundary that serves a reset or NMI request.
- R3: A reset request and an NMI request both raise `hard_exc_o`. Serving one of them clears only its own pending flag, so two such pending requests produce two hard exceptions at two successive boundaries.
- R4: At a boundary that serves a nonzero level L, `cause_ip_o` equals L from the following cycle onward. Bit i of the level maps to bit i of the cause field.
- R5: A level event of value zero is an end-of-interrupt. At the boundary that serves it, `cause_ip_o` becomes zero and no exception is raised. After that, nothing is pending on the level path.
- R6: `intr_exc_o` is raised for a served level L only when `glob_en_i` is 1 and (L AND `mask_i`) is nonzero.
- R7: A level that is blocked (enable low or no unmasked bit) stays pending. It is evaluated again at each later boundary, with the enable and mask values of that boundary, until it is delivered or replaced.
- R8: A new level event replaces any older pending level value.
- R9: Without a boundary strobe, no exception is raised and `cause_ip_o` keeps its value, whatever happens on the request, enable and mask inputs.
- R10: `hard_exc_o` and `intr_exc_o` are combinational pulses. They are high only during a cycle in which `boundary_i` is high, and never both at once. A request latched in the same cycle as a boundary is served at the next boundary.
- R11: Once a level has been delivered, it is no longer pending. A later boundary with the mask fully open raises no interrupt, and the cause field keeps the delivered level.
- R12: A synchronous reset discards all pending requests. Requests latched before the reset are not served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boot_req_i | input | 1 | Reset request pulse from the system |
| nmi_req_i | input | 1 | Non-maskable interrupt request pulse |
| lvl_valid_i | input | 1 | Strobe: a new maskable level is on `lvl_value_i` |
| lvl_value_i | input | LVL_W | Maskable level; zero means end-of-interrupt |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| glob_en_i | input | 1 | Global interrupt enable from the status register |
| mask_i | input | LVL_W | Interrupt mask field from the status register |
| cause_ip_o | output | LVL_W | Hardware-interrupt field of the cause register |
| hard_exc_o | output | 1 | Combined reset/NMI exception request |
| intr_exc_o | output | 1 | Maskable interrupt exception request |

## Verification
The bench uses the default width of six level bits. This is small enough to sweep all 64 level values against all 64 mask values. For each pair, the bench checks whether the interrupt fires, what the cause field holds afterwards, and how a blocked level is retried with the enable low and then with a mask that matches it. Directed sequences cover the priority order, end-of-interrupt, replacement of a pending level, requests with no boundary, and a reset that discards pending requests.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  // State of the maskable level path
  typedef enum logic [1:0] {
    LV_IDLE  = 2'd0,
    LV_ARMED = 2'd1,
    LV_EOI   = 2'd2
  } lvl_state_e;
endpackage

// File: rtl/irqd_flag.sv
module irqd_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // A new request wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/irqd_lvl_track.sv
module irqd_lvl_track
  import irqd_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_i,
  input  logic [LVL_W-1:0] ev_val_i,
  input  logic             take_i,
  output lvl_state_e       state_o,
  output logic [LVL_W-1:0] val_o
);
  function automatic lvl_state_e classify(input logic [LVL_W-1:0] v);
    return (v == '0) ? LV_EOI : LV_ARMED;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= LV_IDLE;
      val_o   <= '0;
    end else if (ev_i) begin
      state_o <= classify(ev_val_i);
      val_o   <= ev_val_i;
    end else if (take_i) begin
      state_o <= LV_IDLE;
    end
  end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
  import irqd_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             bnd_i,
  input  logic             rst_pend_i,
  input  logic             nmi_pend_i,
  input  lvl_state_e       lvl_state_i,
  input  logic [LVL_W-1:0] lvl_val_i,
  input  logic             en_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             clr_rst_o,
  output logic             clr_nmi_o,
  output logic             lvl_take_o,
  output logic             intr_fire_o,
  output logic             cause_we_o,
  output logic [LVL_W-1:0] cause_nxt_o
);
  function automatic logic unmasked(input logic en, input logic [LVL_W-1:0] lv,
                                    input logic [LVL_W-1:0] mk);
    return en && ((lv & mk) != '0);
  endfunction

  logic sel_lvl;

  always_comb begin
    clr_rst_o   = bnd_i && rst_pend_i;
    clr_nmi_o   = bnd_i && !rst_pend_i && nmi_pend_i;
    sel_lvl     = bnd_i && !rst_pend_i && !nmi_pend_i && (lvl_state_i != LV_IDLE);
    cause_we_o  = sel_lvl;
    // clear first, then load for a real level
    cause_nxt_o = (lvl_state_i == LV_ARMED) ? lvl_val_i : '0;
    intr_fire_o = sel_lvl && (lvl_state_i == LV_ARMED) && unmasked(en_i, lvl_val_i, mask_i);
    lvl_take_o  = (sel_lvl && (lvl_state_i == LV_EOI)) || intr_fire_o;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_req_i,
  input  logic             nmi_req_i,
  input  logic             lvl_valid_i,
  input  logic [LVL_W-1:0] lvl_value_i,
  input  logic             boundary_i,
  input  logic             glob_en_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic [LVL_W-1:0] cause_ip_o,
  output logic             hard_exc_o,
  output logic             intr_exc_o
);
  localparam int NSRC = 2; // 0: reset request, 1: NMI

  logic [NSRC-1:0] src_req, src_pend, src_clr;
  lvl_state_e       lvl_state;
  logic [LVL_W-1:0] lvl_val;
  logic             lvl_take, cause_we;
  logic [LVL_W-1:0] cause_nxt;
  logic             rst_pend, nmi_pend, lvl_armed;

  assign src_req = {nmi_req_i, boot_req_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irqd_flag flag_i (
      .clk(clk), .rst(rst), .set_i(src_req[g]), .clr_i(src_clr[g]), .pend_o(src_pend[g])
    );
  end

  assign rst_pend  = src_pend[0];
  assign nmi_pend  = src_pend[1];

  irqd_lvl_track #(.LVL_W(LVL_W)) lvl_i (
    .clk(clk), .rst(rst), .ev_i(lvl_valid_i), .ev_val_i(lvl_value_i),
    .take_i(lvl_take), .state_o(lvl_state), .val_o(lvl_val)
  );

  assign lvl_armed = (lvl_state == LV_ARMED);

  irqd_arbiter #(.LVL_W(LVL_W)) arb_i (
    .bnd_i(boundary_i), .rst_pend_i(rst_pend), .nmi_pend_i(nmi_pend),
    .lvl_state_i(lvl_state), .lvl_val_i(lvl_val), .en_i(glob_en_i), .mask_i(mask_i),
    .clr_rst_o(src_clr[0]), .clr_nmi_o(src_clr[1]), .lvl_take_o(lvl_take),
    .intr_fire_o(intr_exc_o), .cause_we_o(cause_we), .cause_nxt_o(cause_nxt)
  );

  assign hard_exc_o = |src_clr;

  always_ff @(posedge clk) begin
    if (rst)           cause_ip_o <= '0;
    else if (cause_we) cause_ip_o <= cause_nxt;
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             boundary_i,
  input logic             glob_en_i,
  input logic             lvl_valid_i,
  input logic [LVL_W-1:0] cause_ip_o,
  input logic             hard_exc_o,
  input logic             intr_exc_o,
  input logic             rst_pend,
  input logic             nmi_pend,
  input logic             lvl_armed,
  input logic [LVL_W-1:0] lvl_val
);
  AST_PULSE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (hard_exc_o || intr_exc_o) |-> boundary_i); // R10
  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(hard_exc_o && intr_exc_o)); // R2
  AST_HARD_ON_PENDING: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && (rst_pend || nmi_pend)) |-> hard_exc_o); // R3
  AST_INTR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    intr_exc_o |-> glob_en_i); // R6
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !boundary_i |=> $stable(cause_ip_o)); // R9
  AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && lvl_armed && !rst_pend && !nmi_pend) |=> (cause_ip_o == $past(lvl_val))); // R4
  AST_BLOCKED_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && lvl_armed && !intr_exc_o && !lvl_valid_i) |=> lvl_armed); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cause_ip_o == '0 && !rst_pend && !nmi_pend && !lvl_armed)); // R12
endmodule

bind irq_dispatch irq_dispatch_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .boundary_i(boundary_i), .glob_en_i(glob_en_i),
  .lvl_valid_i(lvl_valid_i), .cause_ip_o(cause_ip_o), .hard_exc_o(hard_exc_o),
  .intr_exc_o(intr_exc_o), .rst_pend(rst_pend), .nmi_pend(nmi_pend),
  .lvl_armed(lvl_armed), .lvl_val(lvl_val)
);

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  localparam int W = 6;
  localparam int NV = 1 << W;

  logic clk = 1'b0;
  logic rst;
  logic boot_req, nmi_req, lvl_valid, boundary, glob_en;
  logic [W-1:0] lvl_value, mask;
  logic [W-1:0] cause;
  logic hard, intr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic o_hard, o_intr;
  logic [W-1:0] o_cause;

  always #4 clk = ~clk;

  irq_dispatch #(.LVL_W(W)) dut_i (
    .clk(clk), .rst(rst), .boot_req_i(boot_req), .nmi_req_i(nmi_req),
    .lvl_valid_i(lvl_valid), .lvl_value_i(lvl_value), .boundary_i(boundary),
    .glob_en_i(glob_en), .mask_i(mask), .cause_ip_o(cause),
    .hard_exc_o(hard), .intr_exc_o(intr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle (called right after a negedge); pulses seen before the
  // rising edge, cause seen after it. Returns at the next negedge.
  task automatic cyc(input logic r, input logic b, input logic n, input logic lv,
                     input int val, input logic bd, input logic en, input int mk);
    rst = r; boot_req = b; nmi_req = n; lvl_valid = lv;
    lvl_value = W'(val); boundary = bd; glob_en = en; mask = W'(mk);
    #1;
    o_hard = hard; o_intr = intr;
    @(posedge clk); #1;
    o_cause = cause;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic bnd(input logic en, input int mk);
    cyc(0, 0, 0, 0, 0, 1, en, mk);
  endtask

  task automatic lvl_ev(input int val);
    cyc(0, 0, 0, 1, val, 0, 0, 0);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    // R1 reset state
    idle();
    chk("R1 cause after reset", int'(o_cause), 0);
    chk("R1 hard after reset", int'(o_hard), 0);
    bnd(1, NV-1);
    chk("R1 no hard at empty boundary", int'(o_hard), 0);
    chk("R1 no intr at empty boundary", int'(o_intr), 0);

    // R9 events and mask changes without boundary
    lvl_ev(5);
    cyc(0, 1, 1, 0, 0, 0, 1, NV-1);
    chk("R9 no hard without boundary", int'(o_hard), 0);
    chk("R9 no intr without boundary", int'(o_intr), 0);
    chk("R9 cause held without boundary", int'(o_cause), 0);
    // R2/R3 priority: reset, then NMI, then level
    bnd(1, NV-1);
    chk("R3 hard for reset req", int'(o_hard), 1);
    chk("R2 no intr while reset pending", int'(o_intr), 0);
    chk("R2 cause untouched on reset", int'(o_cause), 0);
    bnd(1, NV-1);
    chk("R3 hard for nmi req", int'(o_hard), 1);
    chk("R2 no intr while nmi pending", int'(o_intr), 0);
    bnd(1, NV-1);
    chk("R3 no third hard", int'(o_hard), 0);
    chk("R2 level served last", int'(o_intr), 1);
    chk("R4 cause loaded", int'(o_cause), 5);
    // R10 request together with boundary waits one boundary
    cyc(0, 0, 1, 0, 0, 1, 0, 0);
    chk("R10 same-cycle nmi not served yet", int'(o_hard), 0);
    bnd(0, 0);
    chk("R10 nmi served next boundary", int'(o_hard), 1);

    // R8 replacement
    lvl_ev(6'h05);
    lvl_ev(6'h20);
    bnd(1, 6'h01);
    chk("R8 old level not delivered", int'(o_intr), 0);
    chk("R8 new level in cause", int'(o_cause), 32);
    // R5 end-of-interrupt replaces blocked level
    lvl_ev(0);
    bnd(1, NV-1);
    chk("R5 no intr on eoi", int'(o_intr), 0);
    chk("R5 cause cleared on eoi", int'(o_cause), 0);
    bnd(1, NV-1);
    chk("R5 nothing pending after eoi", int'(o_intr), 0);
    chk("R5 cause stays clear", int'(o_cause), 0);

    // R12 reset discards pending
    lvl_ev(3);
    cyc(0, 1, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    bnd(1, NV-1);
    chk("R12 no hard after reset", int'(o_hard), 0);
    chk("R12 no intr after reset", int'(o_intr), 0);
    chk("R12 cause zero after reset", int'(o_cause), 0);

    // Exhaustive sweep of level x mask
    for (int l = 0; l < NV; l++) begin
      for (int m = 0; m < NV; m++) begin
        int fire;
        fire = ((l & m) != 0) ? 1 : 0;
        lvl_ev(l);
        bnd(1, m);
        chk($sformatf("R6 fire l=%0d m=%0d", l, m), int'(o_intr), fire);
        chk($sformatf("R4 cause l=%0d m=%0d", l, m), int'(o_cause), l);
        if (l != 0 && fire == 0) begin
          bnd(0, NV-1);
          chk($sformatf("R6 enable low l=%0d", l), int'(o_intr), 0);
          bnd(1, l);
          chk($sformatf("R7 retry delivers l=%0d m=%0d", l, m), int'(o_intr), 1);
        end
        bnd(1, NV-1);
        chk($sformatf("R11 no repeat l=%0d m=%0d", l, m), int'(o_intr), 0);
        chk($sformatf("R11 cause kept l=%0d", l), int'(o_cause), l);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule